// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block is the host side of a three-wire serial EEPROM link. It drives chip select, serial clock and serial data towards the memory, and it samples the memory's data-out line. A request port takes one of seven commands with an address and a data word. The commands are read, write, erase, write-enable, write-disable, erase-all and write-all. The block turns the request into a serial frame and shifts it out, most significant bit first. It samples read data while the frame is still running.

The programming commands are write, erase, erase-all and write-all. For these, the device starts its self-timed cycle only if chip select falls inside one narrow window: after the last frame bit and before the next serial clock rising edge. The controller drops chip select at exactly that point. It then holds chip select low for a minimum deselect time. After that it raises chip select again and watches data-out, with no serial clock pulses, until the device reports ready. A bounded timeout ends this wait with an error. When a write-enable flag input is set, the controller tracks whether writes are enabled. If they are not, it sends the enable frame in front of any programming command by itself.

Top module: `mwire_host`

## Requirements
- R1: After reset `ee_cs` and `ee_sk` are low, `ready` is high and `done` is low.
- R2: Frames start with a 1 bit, are sent MSB first and are sampled by the device on `ee_sk` rising edges. `ee_di` never changes while `ee_sk` is high. Command codes and frames (A = ADDR_W address bits, D = DATA_W data bits):
  - 0 read: `110`, address, then D zero bits.
  - 1 write: `101`, address, data.
  - 2 erase: `111`, address.
  - 3 enable: `100`, address field `11` followed by zeros.
  - 4 disable: `100`, address field `00` followed by zeros.
  - 5 erase-all: `100`, address field `10` followed by zeros.
  - 6 write-all: `100`, address field `01` followed by zeros, then data.
- R3: Chip select falls on the same system clock edge on which `ee_sk` falls after the last frame bit. `ee_sk` never pulses while chip select is low or during polling.
- R4: After every frame and after every poll, `ee_cs` stays low for at least CS_LOW_MIN system clocks before it rises again.
- R5: After a programming command the controller raises `ee_cs` and raises `done` only after it has sampled `ee_do` = 1. A 0 on `ee_do` means busy. In this case `err` is 0.
- R6: For a read, `ee_do` is sampled on the DATA_W rising edges that follow the address bits, MSB first. The word appears on `rd_data` while `done` is high.
- R7: With `auto_wen` = 1, a programming command sent while writes are not enabled is preceded by an enable frame. No enable frame is added once writes are enabled (after reset or a disable they are not).
- R8: If `ee_do` stays 0 for POLL_MAX polling cycles, `done` is raised with `err` = 1.
- R9: A request is taken only while `ready` is high. `req_valid` while busy is ignored. `done` is a single-cycle pulse.
- R10: Inside a frame, `ee_sk` is high for exactly DIV and low for exactly DIV system clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_cmd | input | 3 | Command code (see R2) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Data for write and write-all |
| auto_wen | input | 1 | Insert an enable frame automatically when needed |
| ready | output | 1 | Idle, can take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with done |
| rd_data | output | DATA_W | Read word, valid with done |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data / ready status from the EEPROM |

## Verification
`done` is due CS_LOW_MIN clocks after chip select drops for a non-programming frame. For a programming command it follows the poll and one more deselect of CS_LOW_MIN clocks. `rd_data` and `err` are read in the same cycle as `done`, so the bench waits for `done` at falling clock edges within a bounded count and samples everything there. At the next falling edge it confirms that `done` is low again. A device model in the bench works on system clock edges and sees the controller's registered outputs one edge later. With DIV = 2, it presents each read bit one clock after `ee_sk` falls. The controller samples that bit when it raises `ee_sk` one clock later. The same model measures each clock half-period and each chip-select low time as a count of clocks, and checks where chip select falls relative to `ee_sk`.

// File: rtl/mwire_host.sv
module mwire_host #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int DIV        = 4,
  parameter int CS_LOW_MIN = 8,
  parameter int POLL_MAX   = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              auto_wen,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int HDR = 3 + ADDR_W;
  localparam int FW  = HDR + DATA_W;
  localparam int BW  = $clog2(FW + 1);
  localparam int HW  = $clog2(DIV + 1);
  localparam int GW  = $clog2(CS_LOW_MIN + 1);
  localparam int PW  = $clog2(POLL_MAX + 1);

  localparam logic [2:0] C_READ = 3'd0, C_WRITE = 3'd1, C_ERASE = 3'd2, C_EWEN = 3'd3,
                         C_EWDS = 3'd4, C_ERAL = 3'd5, C_WRAL = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_TAIL, S_DONE} state_t;
  state_t state;

  logic [FW-1:0]     sreg;
  logic [BW-1:0]     bitn, nbits;
  logic [HW-1:0]     hcnt;
  logic [GW-1:0]     gcnt;
  logic [PW-1:0]     pcnt;
  logic [2:0]        cur_cmd, pend_cmd, ld_cmd;
  logic [ADDR_W-1:0] pend_addr, ld_addr;
  logic [DATA_W-1:0] pend_data, ld_data;
  logic              pend, wen, err_q;

  function automatic logic is_prog(input logic [2:0] c);
    return (c == C_WRITE) || (c == C_ERASE) || (c == C_ERAL) || (c == C_WRAL);
  endfunction

  function automatic logic has_data(input logic [2:0] c);
    return (c == C_READ) || (c == C_WRITE) || (c == C_WRAL);
  endfunction

  function automatic logic [FW-1:0] frame_of(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                                             input logic [DATA_W-1:0] d);
    logic [2:0]        h;
    logic [ADDR_W-1:0] af;
    logic [DATA_W-1:0] df;
    h  = 3'b100;
    af = '0;
    df = '0;
    case (c)
      C_READ:  begin h = 3'b110; af = a; end
      C_WRITE: begin h = 3'b101; af = a; df = d; end
      C_ERASE: begin h = 3'b111; af = a; end
      C_EWEN:  af[ADDR_W-1 -: 2] = 2'b11;
      C_ERAL:  af[ADDR_W-1 -: 2] = 2'b10;
      C_WRAL:  begin af[ADDR_W-1 -: 2] = 2'b01; df = d; end
      default: ;
    endcase
    return {h, af, df};
  endfunction

  wire use_en = auto_wen & ~wen & is_prog(req_cmd);
  wire tick   = (hcnt == HW'(DIV - 1));
  wire gap_end = (gcnt == GW'(CS_LOW_MIN - 1));

  always_comb begin
    if (state == S_IDLE) begin
      ld_cmd  = use_en ? C_EWEN : req_cmd;
      ld_addr = req_addr;
      ld_data = req_data;
    end else begin
      ld_cmd  = pend_cmd;
      ld_addr = pend_addr;
      ld_data = pend_data;
    end
  end

  assign ready   = (state == S_IDLE);
  assign done    = (state == S_DONE);
  assign err     = done & err_q;
  assign ee_di   = ee_cs & sreg[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sreg      <= '0;
      bitn      <= '0;
      nbits     <= '0;
      hcnt      <= '0;
      gcnt      <= '0;
      pcnt      <= '0;
      cur_cmd   <= C_READ;
      pend_cmd  <= C_READ;
      pend_addr <= '0;
      pend_data <= '0;
      pend      <= 1'b0;
      wen       <= 1'b0;
      err_q     <= 1'b0;
      rd_data   <= '0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          rd_data   <= '0;
          err_q     <= 1'b0;
          pend      <= use_en;
          pend_cmd  <= req_cmd;
          pend_addr <= req_addr;
          pend_data <= req_data;
          cur_cmd   <= ld_cmd;
          sreg      <= frame_of(ld_cmd, ld_addr, ld_data);
          nbits     <= has_data(ld_cmd) ? BW'(FW) : BW'(HDR);
          bitn      <= '0;
          hcnt      <= '0;
          ee_cs     <= 1'b1;
          state     <= S_SHIFT;
        end
        S_SHIFT: begin
          hcnt <= tick ? '0 : hcnt + 1'b1;
          if (tick && !ee_sk) begin
            ee_sk <= 1'b1;
            if (cur_cmd == C_READ && bitn >= BW'(HDR)) rd_data <= {rd_data[DATA_W-2:0], ee_do};
          end else if (tick) begin
            ee_sk <= 1'b0;
            if (bitn == nbits - BW'(1)) begin
              ee_cs <= 1'b0;
              gcnt  <= '0;
              state <= S_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sreg <= {sreg[FW-2:0], 1'b0};
            end
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gap_end) begin
            if (cur_cmd == C_EWEN) wen <= 1'b1;
            if (cur_cmd == C_EWDS) wen <= 1'b0;
            if (is_prog(cur_cmd)) begin
              ee_cs <= 1'b1;
              pcnt  <= '0;
              state <= S_POLL;
            end else if (pend) begin
              pend    <= 1'b0;
              cur_cmd <= ld_cmd;
              sreg    <= frame_of(ld_cmd, ld_addr, ld_data);
              nbits   <= has_data(ld_cmd) ? BW'(FW) : BW'(HDR);
              bitn    <= '0;
              hcnt    <= '0;
              ee_cs   <= 1'b1;
              state   <= S_SHIFT;
            end else begin
              state <= S_DONE;
            end
          end
        end
        S_POLL: begin
          pcnt <= pcnt + 1'b1;
          if (ee_do || pcnt == PW'(POLL_MAX - 1)) begin
            err_q <= ~ee_do;
            ee_cs <= 1'b0;
            gcnt  <= '0;
            state <= S_TAIL;
          end
        end
        S_TAIL: begin
          gcnt <= gcnt + 1'b1;
          if (gap_end) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs); // R3
  AST_CS_DROP_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_cs) |-> !ee_sk); // R3
  AST_NO_SK_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n) (state == S_POLL) |-> !ee_sk); // R3
  AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R2
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) ready |-> !ee_cs); // R9
endmodule

// File: tb/mwire_host_bench.sv
`timescale 1ns/1ps
module mwire_host_bench;
  localparam int A = 3, D = 8, DIV = 2, CSMIN = 5, PMAX = 300, HDR = 3 + A;
  localparam int BUSY = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, auto_wen = 0;
  logic [2:0] req_cmd = 0;
  logic [A-1:0] req_addr = 0;
  logic [D-1:0] req_data = 0;
  logic ready, done, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [D-1:0] rd_data;

  always #2.5 clk = ~clk;

  mwire_host #(.ADDR_W(A), .DATA_W(D), .DIV(DIV), .CS_LOW_MIN(CSMIN), .POLL_MAX(PMAX)) u_mwire_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_data(req_data), .auto_wen(auto_wen), .ready(ready), .done(done), .err(err),
    .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  // ---------------- device model ----------------
  logic [D-1:0] mem [8];
  logic [31:0] cap, log_cap [4];
  int n, log_n [4], nframes, busy_cnt, bad_drop, sk_bad, gap_bad, half_bad;
  int hi_cnt, lo_cnt, low_cnt;
  logic prev_cs, prev_sk, dev_wen, post_prog, rd_mode, rd_bit, stuck;
  logic [A-1:0] rd_addr;

  assign ee_do = ee_cs & (rd_mode ? rd_bit : (post_prog & ~stuck & (busy_cnt == 0)));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= '1;
      cap <= 0; n <= 0; nframes <= 0; busy_cnt <= 0; bad_drop <= 0; sk_bad <= 0;
      gap_bad <= 0; half_bad <= 0; hi_cnt <= 0; lo_cnt <= 0; low_cnt <= 1000;
      prev_cs <= 0; prev_sk <= 0; dev_wen <= 0; post_prog <= 0; rd_mode <= 0; rd_bit <= 0;
      rd_addr <= 0;
    end else begin
      prev_cs <= ee_cs; prev_sk <= ee_sk;
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (ee_sk) hi_cnt <= hi_cnt + 1;
      else begin
        if (prev_sk && hi_cnt != DIV) half_bad <= half_bad + 1;
        hi_cnt <= 0;
      end
      if (ee_sk && !prev_sk) begin
        if (lo_cnt != DIV) half_bad <= half_bad + 1;
        lo_cnt <= 0;
      end else if (ee_cs && !ee_sk) lo_cnt <= lo_cnt + 1;
      else lo_cnt <= 0;
      if (!ee_cs) low_cnt <= low_cnt + 1;
      if (ee_cs && !prev_cs) begin
        if (low_cnt < CSMIN) gap_bad <= gap_bad + 1;
        low_cnt <= 0;
      end
      if (ee_sk && !prev_sk) begin
        if (!ee_cs || post_prog) sk_bad <= sk_bad + 1;
        cap <= {cap[30:0], ee_di};
        n <= n + 1;
        if (n + 1 == HDR && {cap[HDR-2:0], ee_di} >> A == 3'b110) begin
          rd_mode <= 1; rd_addr <= A'({cap[HDR-2:0], ee_di});
        end
      end
      if (!ee_sk && prev_sk && rd_mode && ee_cs && (n - HDR) < D)
        rd_bit <= mem[rd_addr][D-1-(n-HDR)];
      if (!ee_cs && prev_cs) begin
        rd_mode <= 0; n <= 0; cap <= 0;
        if (n == 0) post_prog <= 0;
        else begin
          log_cap[nframes % 4] <= cap; log_n[nframes % 4] <= n; nframes <= nframes + 1;
          if (!(prev_sk && !ee_sk)) bad_drop <= bad_drop + 1;
          else if (n == HDR + D && (cap >> (A + D)) == 3'b101) begin
            if (dev_wen) mem[(cap >> D) & 7] <= D'(cap);
            post_prog <= 1; busy_cnt <= BUSY;
          end else if (n == HDR + D && (cap >> (A + D)) == 3'b100) begin
            if (dev_wen) for (int i = 0; i < 8; i++) mem[i] <= D'(cap);
            post_prog <= 1; busy_cnt <= BUSY;
          end else if (n == HDR && (cap >> A) == 3'b111) begin
            if (dev_wen) mem[cap & 7] <= '1;
            post_prog <= 1; busy_cnt <= BUSY;
          end else if (n == HDR && (cap >> A) == 3'b100) begin
            case ((cap >> (A - 2)) & 3)
              3: dev_wen <= 1;
              0: dev_wen <= 0;
              2: begin
                if (dev_wen) for (int i = 0; i < 8; i++) mem[i] <= '1;
                post_prog <= 1; busy_cnt <= BUSY;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  int elapsed, nf;
  logic got_err;
  logic [D-1:0] got_rd;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int efr(input int c, input int a, input int d);
    case (c)
      0: return (6 << (A + D)) | (a << D);
      1: return (5 << (A + D)) | (a << D) | d;
      2: return (7 << A) | a;
      3: return (4 << A) | (3 << (A - 2));
      4: return 4 << A;
      5: return (4 << A) | (2 << (A - 2));
      default: return (4 << (A + D)) | (1 << (A - 2 + D)) | d;
    endcase
  endfunction

  function automatic int elen(input int c);
    return (c == 0 || c == 1 || c == 6) ? HDR + D : HDR;
  endfunction

  task automatic run(input int c, input int a, input int d, input bit intrude);
    int n0;
    n0 = nframes;
    @(negedge clk);
    req_valid = 1; req_cmd = 3'(c); req_addr = A'(a); req_data = D'(d);
    @(negedge clk);
    req_valid = 0;
    elapsed = 1;
    while (!done && elapsed < 5000) begin
      @(negedge clk);
      elapsed++;
      if (intrude && elapsed == 30) begin req_valid = 1; req_cmd = 3'd4; end
      else req_valid = 0;
    end
    req_valid = 0;
    chk(done, "R9 done arrives", elapsed, 0);
    got_err = err; got_rd = rd_data; nf = nframes - n0;
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    chk(ready, "R9 ready after done", ready, 1);
  endtask

  task automatic frame_chk(input int c, input int a, input int d, input int slot_back, input string tag);
    int s;
    s = (nframes - 1 - slot_back) % 4;
    chk(log_cap[s] == efr(c, a, d), tag, log_cap[s], efr(c, a, d));
    chk(log_n[s] == elen(c), tag, log_n[s], elen(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    stuck = 0;
    repeat (4) @(negedge clk);
    chk(!ee_cs && !ee_sk && !done && ready, "R1 reset state", {ee_cs, ee_sk, done, ready}, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && ready, "R1 idle after reset", {ee_cs, ee_sk, ready}, 1);

    run(3, 0, 0, 0);
    frame_chk(3, 0, 0, 0, "R2 enable frame");
    for (int a = 0; a < 8; a++) begin
      run(1, a, (a * 29 + 3) & 255, 0);
      frame_chk(1, a, (a * 29 + 3) & 255, 0, "R2 write frame");
      chk(!got_err && elapsed > BUSY + 2 * DIV * HDR, "R5 waited for ready", elapsed, BUSY);
    end
    for (int a = 0; a < 8; a++) begin
      run(0, a, 0, 0);
      frame_chk(0, a, 0, 0, "R2 read frame");
      chk(got_rd == D'((a * 29 + 3) & 255), "R6 read data", got_rd, (a * 29 + 3) & 255);
    end
    run(2, 2, 0, 0);
    frame_chk(2, 2, 0, 0, "R2 erase frame");
    run(0, 2, 0, 0);
    chk(got_rd == 8'hff, "R6 erased word", got_rd, 255);

    run(4, 0, 0, 0);
    frame_chk(4, 0, 0, 0, "R2 disable frame");
    run(1, 3, 8'h11, 0);
    chk(nf == 1, "R7 no auto enable when flag off", nf, 1);
    run(0, 3, 0, 0);
    chk(got_rd == D'((3 * 29 + 3) & 255), "R7 disabled write ignored", got_rd, (3 * 29 + 3) & 255);
    auto_wen = 1;
    run(1, 3, 8'h11, 0);
    chk(nf == 2, "R7 enable inserted", nf, 2);
    frame_chk(3, 0, 0, 1, "R7 enable frame first");
    frame_chk(1, 3, 8'h11, 0, "R7 command frame second");
    run(1, 4, 8'h22, 0);
    chk(nf == 1, "R7 no repeat enable", nf, 1);
    run(0, 3, 0, 0);
    chk(got_rd == 8'h11, "R7 auto enabled write", got_rd, 8'h11);

    run(5, 0, 0, 0);
    frame_chk(5, 0, 0, 0, "R2 erase-all frame");
    for (int a = 0; a < 8; a++) begin
      run(0, a, 0, 0);
      chk(got_rd == 8'hff, "R6 erase-all result", got_rd, 255);
    end
    run(6, 0, 8'h5a, 0);
    frame_chk(6, 0, 8'h5a, 0, "R2 write-all frame");
    for (int a = 0; a < 8; a++) begin
      run(0, a, 0, 0);
      chk(got_rd == 8'h5a, "R6 write-all result", got_rd, 8'h5a);
    end

    stuck = 1;
    run(2, 1, 0, 0);
    chk(got_err, "R8 timeout error", got_err, 1);
    chk(elapsed >= PMAX, "R8 timeout length", elapsed, PMAX);
    stuck = 0;
    run(0, 0, 0, 0);
    chk(!got_err, "R8 error cleared", got_err, 0);

    run(1, 6, 8'h77, 1);
    chk(nf == 1, "R9 busy request ignored", nf, 1);
    run(1, 7, 8'h66, 0);
    chk(nf == 1, "R9 still enabled after ignored disable", nf, 1);
    run(0, 6, 0, 0);
    chk(got_rd == 8'h77, "R9 write kept", got_rd, 8'h77);

    chk(bad_drop == 0, "R3 chip select drop window", bad_drop, 0);
    chk(sk_bad == 0, "R3 no clock while deselected or polling", sk_bad, 0);
    chk(gap_bad == 0, "R4 deselect minimum", gap_bad, 0);
    chk(half_bad == 0, "R10 half period", half_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule